// File: doc/BRIEF.md
# Shared Multiprocessor Control Register with Interval-Tick Gating

This block holds one 64-bit control/status word shared by up to four processors, plus one interval-ignore down-counter per processor. Software writes the shared word through a small CSR port. Different bit groups in that word follow different write rules: some clear when written with a one, some set when written with a one, one group accepts a set only while it is empty, and one group is plain read/write. Bits [11:8] hold one inter-processor interrupt per processor, and software raises them through request bits [15:12]. Bits [7:4] hold one timer interrupt per processor.

A common periodic tick input is shared by all processors. Each processor's counter gates the tick. On every rising tick edge, the counter of each present processor counts down one modulo 2^(CNT_W+1). Bit CNT_W is an overflow flag; it becomes set when the count wraps past zero and then stays set. Each tick that leaves the overflow flag set raises that processor's timer interrupt. Software can therefore skip a chosen number of ticks, and afterwards it can read how many ticks it has missed.

Reads are combinational. A read of the shared word reports the index of the requesting processor in bits [1:0]. A per-processor presence input freezes the counter of an absent processor and holds its interrupt outputs low.

Top module: `smp_misc_ctrl`

## Requirements
- R1: After reset, the shared word reads 0x0000_0008_0000_0000 with bits [1:0] replaced by the requester index (bit 35 is a revision mark), every counter reads 0, and all interrupt outputs are low.
- R2: csr_addr 0 selects the shared word, and bits [1:0] of its read data equal csr_cpu_id. csr_addr 4+i selects the counter of processor i: bits [CNT_W:0] hold the count with the overflow flag at bit CNT_W, and all higher bits read 0.
- R3: In a write to the shared word, each bit written as one inside mask 0x0000_0000_1000_0FF0 is cleared. This covers timer bits [7:4], interrupt bits [11:8] and bit 28.
- R4: In a write to the shared word, a one in bit 12+i sets bit 8+i. This set wins over a clear of bit 8+i in the same write. ipi_irq[i] equals bit 8+i.
- R5: A write with bit 20 set clears bits [23:16]. Otherwise, each one written in [23:20] sets the matching bit.
- R6: When bit 20 is not written, field [19:16] takes the written ones only if its current value is zero. Otherwise the field is left unchanged.
- R7: Bits [43:40] take the written value. Bits outside the groups named in R3 to R7 keep their values on a write, so bit 35 stays set.
- R8: A write to a counter loads bits [CNT_W-1:0] of the write data, clears the overflow flag, and ignores all higher data bits.
- R9: At each rising tick edge, the count of every present processor decrements modulo 2^(CNT_W+1), and the overflow flag stays set once set. A tick that is held high or falls has no effect.
- R10: When the overflow flag is set after a tick, the tick sets bit 4+i. timer_irq[i] equals bit 4+i, so it drops only when an R3 write clears that bit.
- R11: While cpu_present[i] is low, the counter of processor i ignores ticks, ipi_irq[i] and timer_irq[i] are low, and the stored bits and counter writes are unaffected.
- R12: A counter write in the same cycle as a tick edge takes precedence over the decrement. A timer bit set by a tick takes precedence over a clear of that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_present | input | NCPU | One bit per processor; high when the processor exists |
| tick | input | 1 | Shared periodic timer level; rising edges count |
| csr_wr_en | input | 1 | Write strobe for the selected register |
| csr_addr | input | ADDR_W | Register select: 0 for the shared word, 4+i for the counter of processor i |
| csr_wdata | input | 64 | Write data |
| csr_cpu_id | input | 2 | Index of the processor making the access |
| csr_rdata | output | 64 | Combinational read data for csr_addr |
| ipi_irq | output | NCPU | Inter-processor interrupt per processor |
| timer_irq | output | NCPU | Timer interrupt per processor |

## Verification
The write rules are swept over every pairing of the current value of field [19:16] with every written nibble. This sweep separates the take-if-empty behaviour from plain set and from overwrite. Bit 20 is toggled within the same sweep, which separates clear-both from set. Counters are loaded with every value of a narrow 4-bit configuration and then ticked past the wrap. Each processor starts from a different value, so the sweep shows the modulo decrement, the point where the flag becomes set, and the flag staying set, and it catches crossed lanes. Three further cases are tried: a tick held high over several cycles, processors removed while interrupts are pending, and same-cycle collisions. Together they separate edge detection, masking and write priority.

// File: rtl/smp_misc_pkg.sv
package smp_misc_pkg;

  localparam logic [63:0] MISC_RESET = 64'h0000_0008_0000_0000;
  localparam logic [63:0] CLR1_MASK  = 64'h0000_0000_1000_0FF0;
  localparam logic [63:0] PLAIN_MASK = 64'h0000_0F00_0000_0000;

  // Next value of the shared word after a software write.
  function automatic logic [63:0] misc_write(input logic [63:0] cur,
                                             input logic [63:0] wd);
    logic [63:0] n;
    n = cur & ~(wd & CLR1_MASK);
    if (wd[20]) begin
      n[23:16] = 8'h00;
    end else begin
      n[23:20] = n[23:20] | wd[23:20];
      if (n[19:16] == 4'h0) n[19:16] = wd[19:16];
    end
    n[11:8] = n[11:8] | wd[15:12];
    n = (n & ~PLAIN_MASK) | (wd & PLAIN_MASK);
    return n;
  endfunction

endpackage

// File: rtl/smp_ign_cnt.sv
module smp_ign_cnt #(
  parameter int CNT_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           present_i,
  input  logic           wr_en_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic           tick_rise_i,
  output logic [CNT_W:0] cnt_o,
  output logic           ovf_tick_o
);
  localparam int CW = CNT_W + 1;

  // Wrapping decrement with a sticky top bit.
  function automatic logic [CW-1:0] dec_sticky(input logic [CW-1:0] c);
    return (c - CW'(1)) | (c & (CW'(1) << CNT_W));
  endfunction

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] step_val;
  logic          do_step;

  always_comb begin
    step_val   = dec_sticky(cnt_q);
    do_step    = present_i & tick_rise_i & ~wr_en_i;
    ovf_tick_o = do_step & step_val[CNT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_en_i) cnt_q <= {1'b0, wdata_i};
    else if (do_step) cnt_q <= step_val;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/smp_misc_reg.sv
module smp_misc_reg
  import smp_misc_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [63:0]     wdata_i,
  input  logic [NCPU-1:0] iti_set_i,
  output logic [63:0]     q_o
);
  logic [63:0] q;
  logic [63:0] nxt;

  always_comb begin
    nxt = wr_en_i ? misc_write(q, wdata_i) : q;
    for (int i = 0; i < NCPU; i++) begin
      nxt[4+i] = nxt[4+i] | iti_set_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= MISC_RESET;
    else        q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/smp_misc_ctrl.sv
module smp_misc_ctrl #(
  parameter int NCPU   = 4,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCPU-1:0]   cpu_present,
  input  logic              tick,
  input  logic              csr_wr_en,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  input  logic [1:0]        csr_cpu_id,
  output logic [63:0]       csr_rdata,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   timer_irq
);
  localparam int CW = CNT_W + 1;
  localparam logic [ADDR_W-1:0] MISC_ADDR = '0;
  localparam int CNT_BASE = 4;

  logic                     tick_q;
  logic                     tick_rise;
  logic                     misc_wr;
  logic [NCPU-1:0]          cnt_wr;
  logic [NCPU-1:0]          ovf_tick;
  logic [NCPU-1:0][CW-1:0]  cnt_all;
  logic [63:0]              misc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick;
  end

  assign tick_rise = tick & ~tick_q;
  assign misc_wr   = csr_wr_en && (csr_addr == MISC_ADDR);

  genvar g;
  generate
    for (g = 0; g < NCPU; g++) begin : g_cpu
      assign cnt_wr[g] = csr_wr_en && (csr_addr == ADDR_W'(CNT_BASE + g));

      smp_ign_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .present_i  (cpu_present[g]),
        .wr_en_i    (cnt_wr[g]),
        .wdata_i    (csr_wdata[CNT_W-1:0]),
        .tick_rise_i(tick_rise),
        .cnt_o      (cnt_all[g]),
        .ovf_tick_o (ovf_tick[g])
      );

      assign ipi_irq[g]   = misc_q[8+g] & cpu_present[g];
      assign timer_irq[g] = misc_q[4+g] & cpu_present[g];
    end
  endgenerate

  smp_misc_reg #(.NCPU(NCPU)) u_misc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (misc_wr),
    .wdata_i  (csr_wdata),
    .iti_set_i(ovf_tick),
    .q_o      (misc_q)
  );

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == MISC_ADDR) csr_rdata = {misc_q[63:2], csr_cpu_id};
    for (int i = 0; i < NCPU; i++) begin
      if (csr_addr == ADDR_W'(CNT_BASE + i)) csr_rdata = 64'(cnt_all[i]);
    end
  end
endmodule

// File: rtl/smp_misc_ctrl_chk.sv
module smp_misc_ctrl_chk #(
  parameter int NCPU  = 4,
  parameter int CNT_W = 24
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      misc_wr,
  input logic [63:0]               wdata,
  input logic [63:0]               misc_q,
  input logic [NCPU-1:0]           present,
  input logic [NCPU-1:0]           timer_irq,
  input logic [NCPU-1:0]           ovf_tick,
  input logic [NCPU-1:0]           cnt_wr,
  input logic [NCPU-1:0][CNT_W:0]  cnt_all
);
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr |=> (((misc_q[11:8] & $past(wdata[11:8]) & ~$past(wdata[15:12])) == 4'h0)
                 && !(misc_q[28] && $past(wdata[28]))));

  a_r4_ipi_request: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr |=> ((misc_q[11:8] & $past(wdata[15:12])) == $past(wdata[15:12])));

  a_r5_clear_both: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr && wdata[20] |=> (misc_q[23:16] == 8'h00));

  a_r6_hold_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr && !wdata[20] && (misc_q[19:16] != 4'h0) |=> $stable(misc_q[19:16]));

  a_r7_plain_rw: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr |=> (misc_q[43:40] == $past(wdata[43:40])) && misc_q[35]);

  genvar g;
  generate
    for (g = 0; g < NCPU; g++) begin : g_chk
      a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr[g] |=> (cnt_all[g] == {1'b0, $past(wdata[CNT_W-1:0])}));

      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_all[g][CNT_W] && !cnt_wr[g] |=> cnt_all[g][CNT_W]);

      a_r10_timer_raise: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_tick[g] && present[g] |=> timer_irq[g] || !present[g]);

      a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !present[g] && !cnt_wr[g] |=> $stable(cnt_all[g]));
    end
  endgenerate
endmodule

bind smp_misc_ctrl smp_misc_ctrl_chk #(.NCPU(NCPU), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .misc_wr  (misc_wr),
  .wdata    (csr_wdata),
  .misc_q   (misc_q),
  .present  (cpu_present),
  .timer_irq(timer_irq),
  .ovf_tick (ovf_tick),
  .cnt_wr   (cnt_wr),
  .cnt_all  (cnt_all)
);

// File: tb/tb_smp_misc_ctrl.sv
module tb_smp_misc_ctrl;
  localparam int NC = 4;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] cpu_present = 4'hF;
  logic          tick = 1'b0;
  logic          csr_wr_en = 1'b0;
  logic [2:0]    csr_addr = 3'd0;
  logic [63:0]   csr_wdata = 64'h0;
  logic [1:0]    csr_cpu_id = 2'd0;
  logic [63:0]   csr_rdata;
  logic [NC-1:0] ipi_irq;
  logic [NC-1:0] timer_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0]   m_misc;
  logic [CW-1:0] m_cnt [NC];

  always #10 clk = ~clk;

  smp_misc_ctrl #(.NCPU(NC), .CNT_W(CW-1), .ADDR_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_present(cpu_present), .tick(tick),
    .csr_wr_en(csr_wr_en), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_cpu_id(csr_cpu_id), .csr_rdata(csr_rdata),
    .ipi_irq(ipi_irq), .timer_irq(timer_irq)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // Bench view of a write to the shared word, bit by bit.
  task automatic model_misc_write(input logic [63:0] w);
    for (int b = 4; b < 12; b++) if (w[b]) m_misc[b] = 1'b0;
    if (w[28]) m_misc[28] = 1'b0;
    if (w[20]) begin
      for (int b = 16; b < 24; b++) m_misc[b] = 1'b0;
    end else begin
      for (int b = 20; b < 24; b++) if (w[b]) m_misc[b] = 1'b1;
      if (m_misc[19:16] == 4'h0) m_misc[19:16] = w[19:16];
    end
    for (int k = 0; k < 4; k++) if (w[12+k]) m_misc[8+k] = 1'b1;
    m_misc[43:40] = w[43:40];
  endtask

  task automatic model_tick(input int skip);
    for (int i = 0; i < NC; i++) begin
      if (cpu_present[i] && i != skip) begin
        logic [CW-1:0] v;
        logic [CW-1:0] nv;
        int n;
        v = m_cnt[i];
        n = (v == 0) ? 31 : int'(v) - 1;
        nv = n[CW-1:0];
        if (v[CW-1]) nv[CW-1] = 1'b1;
        m_cnt[i] = nv;
        if (nv[CW-1]) m_misc[4+i] = 1'b1;
      end
    end
  endtask

  task automatic check_all(input string tag);
    for (int id = 0; id < 4; id++) begin
      csr_addr = 3'd0;
      csr_cpu_id = id[1:0];
      #1;
      cmp(tag, "R2 shared word read", csr_rdata, {m_misc[63:2], id[1:0]});
    end
    for (int i = 0; i < NC; i++) begin
      csr_addr = 3'(4 + i);
      #1;
      cmp(tag, "R2 counter read", csr_rdata, 64'(m_cnt[i]));
    end
    cmp(tag, "ipi_irq", 64'(ipi_irq), 64'(m_misc[11:8] & cpu_present));
    cmp(tag, "timer_irq", 64'(timer_irq), 64'(m_misc[7:4] & cpu_present));
    csr_addr = 3'd0;
  endtask

  // One access and/or tick, then an idle cycle, then a full comparison.
  task automatic step(input bit we, input logic [2:0] a, input logic [63:0] d,
                      input bit tk, input string tag);
    int skip;
    csr_wr_en = we;
    csr_addr = a;
    csr_wdata = d;
    tick = tk;
    @(posedge clk);
    skip = -1;
    if (we) begin
      if (a == 3'd0) model_misc_write(d);
      else if (a >= 3'd4) begin
        m_cnt[a-3'd4] = {1'b0, d[CW-2:0]};
        skip = int'(a) - 4;
      end
    end
    if (tk) model_tick(skip);
    @(negedge clk);
    csr_wr_en = 1'b0;
    tick = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_misc = 64'h0000_0008_0000_0000;
    for (int i = 0; i < NC; i++) m_cnt[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R4: request bits raise IPIs; R3: ones clear them and bit 28
    step(1, 3'd0, 64'h0000_0000_0000_F000, 0, "R4");
    step(1, 3'd0, 64'h0000_0000_0000_0500, 0, "R3");
    step(1, 3'd0, 64'h0000_0000_0000_1100, 0, "R4");
    step(1, 3'd0, 64'h0000_0000_1000_0F00, 0, "R3");

    // R5 / R6: sweep current [19:16] against every written nibble
    for (int cur = 0; cur < 16; cur++) begin
      for (int w = 0; w < 16; w++) begin
        step(1, 3'd0, 64'h0000_0000_0010_0000, 0, "R5");
        step(1, 3'd0, 64'(cur) << 16, 0, "R6");
        step(1, 3'd0, (64'(w) << 16) | (64'(w & 14) << 20), 0, "R6");
      end
    end
    step(1, 3'd0, 64'h0000_0000_00E0_0000, 0, "R5");
    step(1, 3'd0, 64'h0000_0000_0010_0000, 0, "R5");

    // R7: plain field follows writes, other bits hold
    step(1, 3'd0, 64'hFFFF_FAFF_EF0E_E00F, 0, "R7");
    step(1, 3'd0, 64'h0000_0000_0000_0000, 0, "R7");
    step(1, 3'd0, 64'h0000_0500_0000_0000, 0, "R7");

    // R8: counter loads only its low bits
    for (int i = 0; i < NC; i++)
      step(1, 3'(4 + i), 64'hFFFF_FFFF_FFFF_FFF0 | 64'(3 * i + 1), 0, "R8");

    // R9 / R10: every start value, ticked through the wrap
    for (int v = 0; v < 16; v++) begin
      for (int i = 0; i < NC; i++)
        step(1, 3'(4 + i), 64'((v + 5 * i) & 15), 0, "R8");
      step(1, 3'd0, 64'h0000_0000_0000_00F0, 0, "R10");
      for (int t = 0; t < 18; t++) step(0, 3'd0, 64'h0, 1, "R9");
      step(1, 3'd0, 64'h0000_0000_0000_0010, 0, "R10");
      step(0, 3'd0, 64'h0, 1, "R10");
    end

    // R9: a held level gives one decrement only
    for (int i = 0; i < NC; i++) step(1, 3'(4 + i), 64'd9, 0, "R8");
    tick = 1'b1;
    @(posedge clk);
    model_tick(-1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R9");
    tick = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R9");

    // R11: absent processors are masked and frozen
    step(1, 3'd0, 64'h0000_0000_0000_0FF0, 0, "R11");
    cpu_present = 4'b0101;
    step(1, 3'd0, 64'h0000_0000_0000_F000, 0, "R11");
    for (int t = 0; t < 12; t++) step(0, 3'd0, 64'h0, 1, "R11");
    step(1, 3'd5, 64'd7, 0, "R11");
    step(0, 3'd0, 64'h0, 1, "R11");
    cpu_present = 4'hF;
    @(negedge clk);
    check_all("R11");

    // R12: write against tick in the same cycle
    step(1, 3'd4, 64'd3, 0, "R12");
    step(1, 3'd4, 64'd11, 1, "R12");
    step(1, 3'd6, 64'd0, 0, "R12");
    step(0, 3'd0, 64'h0, 1, "R12");
    step(1, 3'd0, 64'h0000_0000_0000_0040, 1, "R12");
    step(1, 3'd0, 64'h0000_0000_0000_00F0, 0, "R12");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule